// File: doc/BRIEF.md
# Frozen Delay-Line Readout Sequencer

This block sequences a capture front end in which an analogue sampled delay line sits ahead of a slow converter. Once armed, it keeps the fast sampling clock of the line running. A trigger then stops that clock, so that the last DEPTH samples stay frozen in the line. The block then selects a slow readout clock and shifts the record out one position per slow tick, at a pace the converter can follow.

For each shifted position it decides whether the converter should take that sample. It issues a conversion strobe together with the position index of the sample inside the frozen record. In roll operation (factor 1) every position is converted. In refreshed operation (factor N > 1) only one position in N is converted. The starting phase rotates by one on each sweep, so that N sweeps together cover the whole record in equivalent time.

A finished sweep parks the block in a done state until it is acknowledged. Only then is a new arm request accepted.

Top module: `dlc_readout_seq`

## Requirements
- R1: After reset, `fast_clk_run`, `clk_sel_slow`, `shift_stb`, `conv_stb` and `done` are all low.
- R2: An `arm_req` seen while idle makes `fast_clk_run` high (and `clk_sel_slow` low) from the next cycle until a trigger.
- R3: A `trig` seen while the fast clock runs drops `fast_clk_run` and raises `clk_sel_slow` in the next cycle.
- R4: A readout produces exactly DEPTH one-cycle `shift_stb` pulses, consecutive pulses RD_DIV cycles apart, and no pulse outside readout except the final one, which shows in the first done cycle.
- R5: With an effective factor of 1, every shifted position is converted: DEPTH conversion strobes carrying indices 0, 1, ..., DEPTH-1 in ascending order.
- R6: With an effective factor N > 1, `conv_stb` rises only together with `shift_stb`, and only for positions p with p mod N equal to the current offset; `sample_idx` then equals p.
- R7: The offset starts at 0 after reset. It advances by one after each completed sweep and wraps to 0 after N-1. It is reset to 0 when the factor latched at arm differs from the factor of the previous sweep (the factor held after reset is 1).
- R8: After the last shift, `done` stays high, with the fast clock stopped, until `done_ack`; `arm_req` during readout or done has no effect, and after the acknowledge the block is idle.
- R9: A `trig` seen while idle has no effect: neither `clk_sel_slow` nor `fast_clk_run` rises, and no strobe appears.
- R10: `dec_factor` is latched at the accepted arm and later changes have no effect on the sweep; a value of 0 is used as 1, and a value above MAX_DEC is used as MAX_DEC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_req | input | 1 | Request to start capturing (accepted only when idle) |
| trig | input | 1 | Trigger event (acted on only while armed) |
| done_ack | input | 1 | Acknowledge of a finished sweep |
| dec_factor | input | DEC_W | Requested decimation factor N, latched at arm |
| fast_clk_run | output | 1 | Enable for the fast sampling clock of the line |
| clk_sel_slow | output | 1 | Selects the slow readout clock |
| shift_stb | output | 1 | One-cycle shift pulse to the line during readout |
| conv_stb | output | 1 | One-cycle conversion strobe to the converter |
| sample_idx | output | IDX_W | Record position of the sample being converted |
| done | output | 1 | Sweep finished, waiting for acknowledge |

## Verification
On every cycle, the bound checker enforces the state-to-state steps seen at the ports: arm to running, trigger to frozen readout, done held until acknowledged, and a trigger while idle being ignored. It also checks the pulse shape of the strobes, and that the DEPTH-th shift pulse coincides with the rise of `done`. Which positions are converted, the exact indices, the rotation of the offset over several sweeps, the clamping of the factor and its latching at arm can only be shown by the bench. Its scoreboard predicts each sweep's index list and compares it against the stream of conversion strobes.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_ARMED   = 2'd1,
      ST_READOUT = 2'd2,
      ST_DONE    = 2'd3
   } dlc_state_e;
endpackage

// File: rtl/dlc_seq_fsm.sv
module dlc_seq_fsm
   import dlc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       arm_req,
   input  logic       trig,
   input  logic       done_ack,
   input  logic       last_shift,
   output dlc_state_e state_q,
   output logic       arm_take
);
   dlc_state_e state_d;

   assign arm_take = (state_q == ST_IDLE) && arm_req;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:    if (arm_req)    state_d = ST_ARMED;
         ST_ARMED:   if (trig)       state_d = ST_READOUT;
         ST_READOUT: if (last_shift) state_d = ST_DONE;
         ST_DONE:    if (done_ack)   state_d = ST_IDLE;
         default:                    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end
endmodule

// File: rtl/dlc_slow_tick.sv
module dlc_slow_tick #(
   parameter int RD_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (RD_DIV == 1) begin : g_every
         assign tick = run;
      end else begin : g_count
         localparam int CNT_W = $clog2(RD_DIV);
         logic [CNT_W-1:0] cnt_q;
         logic             wrap;
         assign wrap = (cnt_q == CNT_W'(RD_DIV - 1));
         assign tick = run && wrap;
         always_ff @(posedge clk) begin
            if (!rst_n || !run) cnt_q <= '0;
            else if (wrap)      cnt_q <= '0;
            else                cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/dlc_decim.sv
module dlc_decim #(
   parameter  int DEPTH   = 512,
   parameter  int MAX_DEC = 8,
   localparam int IDX_W   = $clog2(DEPTH),
   localparam int DEC_W   = $clog2(MAX_DEC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DEC_W-1:0] dec_in,
   input  logic             run,
   input  logic             tick,
   output logic             shift_stb,
   output logic             conv_stb,
   output logic [IDX_W-1:0] sample_idx,
   output logic             last_shift
);
   logic [IDX_W-1:0] pos_q;
   logic             hit;

   assign last_shift = tick && (pos_q == IDX_W'(DEPTH - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || !run) pos_q <= '0;
      else if (tick)      pos_q <= pos_q + IDX_W'(1);
   end

   generate
      if (MAX_DEC == 1) begin : g_roll_only
         assign hit = 1'b1;
      end else begin : g_refresh
         logic [DEC_W-1:0] dec_eff;
         logic [DEC_W-1:0] dec_q;
         logic [DEC_W-1:0] ofs_q;
         logic [DEC_W-1:0] ph_q;

         always_comb begin
            if (dec_in == '0)                   dec_eff = DEC_W'(1);
            else if (dec_in > DEC_W'(MAX_DEC))  dec_eff = DEC_W'(MAX_DEC);
            else                                dec_eff = dec_in;
         end

         assign hit = (ph_q == ofs_q);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               dec_q <= DEC_W'(1);
               ofs_q <= '0;
               ph_q  <= '0;
            end else begin
               if (load) begin
                  dec_q <= dec_eff;
                  if (dec_eff != dec_q) ofs_q <= '0;
               end
               if (last_shift)
                  ofs_q <= (ofs_q == dec_q - DEC_W'(1)) ? '0 : ofs_q + DEC_W'(1);
               if (!run)
                  ph_q <= '0;
               else if (tick)
                  ph_q <= (ph_q == dec_q - DEC_W'(1)) ? '0 : ph_q + DEC_W'(1);
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shift_stb  <= 1'b0;
         conv_stb   <= 1'b0;
         sample_idx <= '0;
      end else begin
         shift_stb <= tick;
         conv_stb  <= tick && hit;
         if (tick && hit) sample_idx <= pos_q;
      end
   end
endmodule

// File: rtl/dlc_readout_seq.sv
module dlc_readout_seq
   import dlc_pkg::*;
#(
   parameter  int DEPTH   = 512,
   parameter  int MAX_DEC = 8,
   parameter  int RD_DIV  = 4,
   localparam int IDX_W   = $clog2(DEPTH),
   localparam int DEC_W   = $clog2(MAX_DEC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_req,
   input  logic             trig,
   input  logic             done_ack,
   input  logic [DEC_W-1:0] dec_factor,
   output logic             fast_clk_run,
   output logic             clk_sel_slow,
   output logic             shift_stb,
   output logic             conv_stb,
   output logic [IDX_W-1:0] sample_idx,
   output logic             done
);
   generate
      if (DEPTH < 2)                    begin : g_bad_depth $error("DEPTH must be at least 2"); end
      if (MAX_DEC < 1 || MAX_DEC > DEPTH) begin : g_bad_dec $error("MAX_DEC must be in 1..DEPTH"); end
      if (RD_DIV < 1)                   begin : g_bad_div   $error("RD_DIV must be at least 1"); end
   endgenerate

   dlc_state_e state_q;
   logic       arm_take;
   logic       last_shift;
   logic       tick;
   logic       in_readout;

   assign in_readout   = (state_q == ST_READOUT);
   assign fast_clk_run = (state_q == ST_ARMED);
   assign clk_sel_slow = in_readout;
   assign done         = (state_q == ST_DONE);

   dlc_seq_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm_req    (arm_req),
      .trig       (trig),
      .done_ack   (done_ack),
      .last_shift (last_shift),
      .state_q    (state_q),
      .arm_take   (arm_take)
   );

   dlc_slow_tick #(.RD_DIV(RD_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (in_readout),
      .tick  (tick)
   );

   dlc_decim #(.DEPTH(DEPTH), .MAX_DEC(MAX_DEC)) u_decim (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (arm_take),
      .dec_in     (dec_factor),
      .run        (in_readout),
      .tick       (tick),
      .shift_stb  (shift_stb),
      .conv_stb   (conv_stb),
      .sample_idx (sample_idx),
      .last_shift (last_shift)
   );
endmodule

// File: rtl/dlc_readout_seq_chk.sv
module dlc_readout_seq_chk #(
   parameter  int DEPTH  = 512,
   parameter  int RD_DIV = 4,
   localparam int CNT_W  = $clog2(DEPTH) + 1
) (
   input logic clk,
   input logic rst_n,
   input logic arm_req,
   input logic trig,
   input logic done_ack,
   input logic fast_clk_run,
   input logic clk_sel_slow,
   input logic shift_stb,
   input logic conv_stb,
   input logic done
);
   logic [CNT_W-1:0] shift_cnt;
   logic             idle_seen;

   assign idle_seen = !fast_clk_run && !clk_sel_slow && !done;

   always_ff @(posedge clk) begin
      if (!rst_n || fast_clk_run) shift_cnt <= '0;
      else if (shift_stb)         shift_cnt <= shift_cnt + CNT_W'(1);
   end

   p_arm_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
      idle_seen && arm_req |=> fast_clk_run && !clk_sel_slow);

   p_trig_freezes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fast_clk_run && trig |=> clk_sel_slow && !fast_clk_run);

   p_shift_in_readout_r4: assert property (@(posedge clk) disable iff (!rst_n)
      shift_stb |-> (clk_sel_slow || done));

   p_shift_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      shift_stb && (RD_DIV > 1) |=> !shift_stb);

   p_full_record_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> shift_stb && (shift_cnt == CNT_W'(DEPTH - 1)));

   p_conv_with_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
      conv_stb |-> shift_stb);

   p_done_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done && !done_ack |=> done && !fast_clk_run);

   p_idle_trig_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      idle_seen && !arm_req && trig |=> !clk_sel_slow && !fast_clk_run);
endmodule

bind dlc_readout_seq dlc_readout_seq_chk #(.DEPTH(DEPTH), .RD_DIV(RD_DIV)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .arm_req      (arm_req),
   .trig         (trig),
   .done_ack     (done_ack),
   .fast_clk_run (fast_clk_run),
   .clk_sel_slow (clk_sel_slow),
   .shift_stb    (shift_stb),
   .conv_stb     (conv_stb),
   .done         (done)
);

// File: tb/dlc_readout_seq_tb.sv
module dlc_readout_seq_tb;
   localparam int DEPTH   = 512;
   localparam int MAX_DEC = 8;
   localparam int RD_DIV  = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       arm_req = 1'b0;
   logic       trig = 1'b0;
   logic       done_ack = 1'b0;
   logic [3:0] dec_factor = 4'd1;
   logic       fast_clk_run, clk_sel_slow, shift_stb, conv_stb, done;
   logic [8:0] sample_idx;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int last_shift_cyc = 0;
   int sweep_shifts = 0;
   int stray_shifts = 0;
   int exp_q[$];
   int exp_ofs = 0;
   int prev_dec = 1;
   bit in_sweep = 1'b0;

   always #4 clk = ~clk;

   dlc_readout_seq #(.DEPTH(DEPTH), .MAX_DEC(MAX_DEC), .RD_DIV(RD_DIV)) u_dut (
      .clk (clk), .rst_n (rst_n), .arm_req (arm_req), .trig (trig),
      .done_ack (done_ack), .dec_factor (dec_factor),
      .fast_clk_run (fast_clk_run), .clk_sel_slow (clk_sel_slow),
      .shift_stb (shift_stb), .conv_stb (conv_stb),
      .sample_idx (sample_idx), .done (done)
   );

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard on every conversion strobe
   always @(negedge clk) begin
      if (shift_stb) begin
         if (!in_sweep) stray_shifts++;
         if (sweep_shifts > 0)
            check(cyc - last_shift_cyc == RD_DIV, "R4 shift spacing", cyc - last_shift_cyc, RD_DIV);
         last_shift_cyc = cyc;
         sweep_shifts++;
      end
      if (conv_stb) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R6 R7 unexpected conversion", int'(sample_idx), -1);
         end else begin
            int e;
            e = exp_q.pop_front();
            check(int'(sample_idx) == e, "R5 R6 R7 sample index", int'(sample_idx), e);
         end
      end
   end

   task automatic do_sweep(input logic [3:0] din, input bit arm_in_readout);
      int eff;
      eff = (din == 0) ? 1 : ((din > MAX_DEC) ? MAX_DEC : int'(din));
      if (eff != prev_dec) exp_ofs = 0;
      for (int p = exp_ofs; p < DEPTH; p += eff) exp_q.push_back(p);
      sweep_shifts = 0;
      in_sweep = 1'b1;
      @(negedge clk);
      dec_factor = din;
      arm_req = 1'b1;
      @(negedge clk);
      arm_req = 1'b0;
      check(fast_clk_run && !clk_sel_slow, "R2 armed", int'(fast_clk_run), 1);
      dec_factor = ~din;  // R10: must not affect this sweep
      repeat (5) @(negedge clk);
      check(fast_clk_run, "R2 still armed", int'(fast_clk_run), 1);
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      check(clk_sel_slow && !fast_clk_run, "R3 frozen", int'(clk_sel_slow), 1);
      if (arm_in_readout) arm_req = 1'b1;
      while (!done) @(negedge clk);
      @(negedge clk);
      check(exp_q.size() == 0, "R5 R6 missing conversions", exp_q.size(), 0);
      check(sweep_shifts == DEPTH, "R4 shift count", sweep_shifts, DEPTH);
      exp_q.delete();
      arm_req = 1'b1;  // R8: ignored while done
      repeat (3) @(negedge clk);
      check(done && !fast_clk_run, "R8 done held", int'(done), 1);
      arm_req = 1'b0;
      done_ack = 1'b1;
      @(negedge clk);
      done_ack = 1'b0;
      check(!done && !fast_clk_run && !clk_sel_slow, "R8 idle after ack", int'(done), 0);
      in_sweep = 1'b0;
      prev_dec = eff;
      exp_ofs = (exp_ofs + 1) % eff;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog", cyc, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!fast_clk_run && !clk_sel_slow && !shift_stb && !conv_stb && !done,
            "R1 reset outputs", int'(fast_clk_run | clk_sel_slow | done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!fast_clk_run && !done, "R1 idle after reset", int'(fast_clk_run), 0);
      // R9: trigger while idle
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      repeat (2 * RD_DIV) @(negedge clk);
      check(!clk_sel_slow && !fast_clk_run, "R9 idle trigger", int'(clk_sel_slow), 0);
      check(stray_shifts == 0, "R9 no strobes", stray_shifts, 0);
      do_sweep(4'd1, 1'b0);              // R5 roll
      for (int s = 0; s < 4; s++)        // R6 R7 rotation and wrap
         do_sweep(4'd3, 1'b0);
      do_sweep(4'd0, 1'b0);              // R10 zero used as one, R7 offset reset
      do_sweep(4'd12, 1'b0);             // R10 clamp to MAX_DEC
      do_sweep(4'd8, 1'b1);              // R8 arm during readout, R7 offset 1
      check(stray_shifts == 0, "R4 strobes outside sweep", stray_shifts, 0);
      finish_run();
   end
endmodule